// File: doc/BRIEF.md
# Link Power State Controller

This block is the device-side keeper of the interface operating state. It holds one of six states: reset, ready, active, and three suspended or low-power states. It decides whether the host may touch the register space and whether a channel start command can be accepted. It also watches the physical link for idle time, so the device can suspend itself. Every state change is announced to the event producer with a one-cycle strobe. The new state code is shown on the same cycle.

Suspend has two separate paths. The device suspends itself after a programmable stretch of link inactivity, which gives the light suspend state. A further idle stretch drops it into the low-power state. Link traffic in either of those states wakes the controller back to active. The deep suspend state is reached only when the host writes a request for it. It is left only when the host writes a request for active, and link traffic is ignored while in it. A host request that the current state does not allow changes nothing. It sets an error flag that stays set until the next reset.

Top module: `link_pm_ctrl`

## Requirements
- R1: While and after synchronous reset `rst` is high, `state_o` reads 0 (reset state) and `access_ok`, `chan_ok`, `trans_pulse` and `err_flag` are all 0.
- R2: The controller leaves the reset state only for the ready state (code 1), on the first clock edge at which `dev_ready` is high. A host request made in the reset state does not change the state.
- R3: In the ready state a host request with `req_code` = 2 moves the controller to the active state (code 2). `access_ok` is 1 in every state except the reset state, from the cycle that state is shown on `state_o`.
- R4: `chan_ok` is 1 for one cycle, the cycle after a clock edge at which `chan_start` was high while `state_o` was 2. Otherwise it stays 0.
- R5: In the active state, after `m1_limit` consecutive clock edges with `link_active` low, the controller moves to the light suspend state (code 3).
- R6: In state 3 or state 4, `link_active` high at a clock edge returns the controller to state 2.
- R7: In state 3, after `m2_limit` consecutive clock edges with `link_active` low, the controller moves to the low-power state (code 4).
- R8: A host request with `req_code` = 5 in state 2, 3 or 4 moves the controller to the host suspend state (code 5). In state 5, `link_active` has no effect.
- R9: In state 5 a host request with `req_code` = 2 resumes the controller to state 2.
- R10: Any other host request, including any request made in the reset state or with a code above 5, leaves the state unchanged. It sets `err_flag`, which stays 1 until reset.
- R11: Each state change raises `trans_pulse` for exactly one cycle. In that cycle `state_o` already shows the new code. `trans_pulse` never rises without a change.
- R12: When a legal host request and a link event (activity or timeout) arrive at the same edge, the host request decides the next state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_ready | input | 1 | Device has finished its own bring-up |
| link_active | input | 1 | Activity seen on the physical link this cycle |
| req_valid | input | 1 | Host writes a state request this cycle |
| req_code | input | 3 | Requested state code |
| chan_start | input | 1 | Channel start command presented |
| m1_limit | input | 16 | Idle edges in state 2 before the device suspends |
| m2_limit | input | 16 | Idle edges in state 3 before falling to low power |
| state_o | output | 3 | Current state code (0..5) |
| access_ok | output | 1 | Host register access permitted |
| chan_ok | output | 1 | Channel start accepted (one-cycle pulse) |
| trans_pulse | output | 1 | One-cycle strobe on every state change |
| err_flag | output | 1 | Sticky illegal-request flag |

## Verification
Every output is one register past its cause. A request, activity pulse or channel start driven before a clock edge shows its result on the outputs just after that edge. The bench drives on falling edges and reads the outputs on the following falling edge. For the idle timers it counts falling edges from the moment `link_active` drops. It checks that the state is unchanged after one edge fewer than the limit, and has changed after exactly the limit. A scoreboard queue holds the state each expected change should produce. A monitor that samples just after each rising edge pops the queue on every `trans_pulse` and compares. An unexpected strobe, or an expected one that never arrives, counts as an error.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    ST_RESET = 3'd0,
    ST_READY = 3'd1,
    ST_M0    = 3'd2,
    ST_M1    = 3'd3,
    ST_M2    = 3'd4,
    ST_M3    = 3'd5
  } lpm_state_e;
endpackage

// File: rtl/lpm_req_check.sv
// Decides whether a host state request is allowed from the current state.
module lpm_req_check
  import lpm_pkg::*;
(
  input  lpm_state_e        cur,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  output logic              legal,
  output logic              bad
);
  logic allowed;

  always_comb begin
    allowed = 1'b0;
    unique case (cur)
      ST_READY:             allowed = (req_code == ST_M0);
      ST_M0, ST_M1, ST_M2:  allowed = (req_code == ST_M3);
      ST_M3:                allowed = (req_code == ST_M0);
      default:              allowed = 1'b0;
    endcase
  end

  assign legal = req_valid & allowed;
  assign bad   = req_valid & ~allowed;
endmodule

// File: rtl/lpm_idle_timer.sv
// Counts consecutive idle link cycles in the active and light-suspend states.
module lpm_idle_timer
  import lpm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  lpm_state_e       cur,
  input  logic             link_active,
  input  logic             restart,
  input  logic [CNT_W-1:0] m1_limit,
  input  logic [CNT_W-1:0] m2_limit,
  output logic             expire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             counting;
  logic [CNT_W:0]   cnt_inc;

  assign counting = (cur == ST_M0) || (cur == ST_M1);
  assign limit    = (cur == ST_M1) ? m2_limit : m1_limit;
  assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign expire   = counting && !link_active && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || restart || !counting || link_active) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6: activity always restarts the idle count
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (rst)
    link_active |=> (cnt_q == '0));
endmodule

// File: rtl/lpm_state_core.sv
// Six-state operating-state machine with registered outputs.
module lpm_state_core
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_ready,
  input  logic              link_active,
  input  logic              req_legal,
  input  logic              req_bad,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              chan_start,
  input  logic              expire,
  output lpm_state_e        state_q,
  output logic              restart,
  output logic              access_ok,
  output logic              chan_ok,
  output logic              trans_pulse,
  output logic              err_flag
);
  lpm_state_e nxt;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      ST_RESET: if (dev_ready) nxt = ST_READY;
      ST_READY: if (req_legal) nxt = lpm_state_e'(req_code);
      ST_M0: begin
        if (req_legal)   nxt = lpm_state_e'(req_code);
        else if (expire) nxt = ST_M1;
      end
      ST_M1: begin
        if (req_legal)        nxt = lpm_state_e'(req_code);
        else if (link_active) nxt = ST_M0;
        else if (expire)      nxt = ST_M2;
      end
      ST_M2: begin
        if (req_legal)        nxt = lpm_state_e'(req_code);
        else if (link_active) nxt = ST_M0;
      end
      ST_M3:    if (req_legal) nxt = lpm_state_e'(req_code);
      default:  nxt = ST_RESET;
    endcase
  end

  assign restart = (nxt != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RESET;
      access_ok   <= 1'b0;
      chan_ok     <= 1'b0;
      trans_pulse <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      state_q     <= nxt;
      access_ok   <= (nxt != ST_RESET);
      chan_ok     <= chan_start && (state_q == ST_M0);
      trans_pulse <= restart;
      if (req_bad) err_flag <= 1'b1;
    end
  end

  // R11: a strobe always accompanies a real change of state
  p_strobe_change_r11: assert property (@(posedge clk) disable iff (rst)
    trans_pulse |-> (state_q != $past(state_q)));

  // R4: an accepted channel start traces back to the active state
  p_chan_gate_r4: assert property (@(posedge clk) disable iff (rst)
    chan_ok |-> $past(chan_start && state_q == ST_M0));

  // R8: the host suspend state is only entered on a host request
  p_m3_by_host_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_M3 && $past(state_q) != ST_M3)
      |-> $past(req_valid && req_code == ST_M3));

  // R7: low power is reached only from light suspend
  p_m2_from_m1_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_M2 && $past(state_q) != ST_M2) |-> ($past(state_q) == ST_M1));

  // R10: the error flag never clears outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  // R2: the reset state is only left for ready
  p_reset_exit_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_RESET && state_q != ST_RESET) |-> (state_q == ST_READY));
endmodule

// File: rtl/link_pm_ctrl.sv
module link_pm_ctrl
  import lpm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_ready,
  input  logic              link_active,
  input  logic              req_valid,
  input  logic [2:0]        req_code,
  input  logic              chan_start,
  input  logic [CNT_W-1:0]  m1_limit,
  input  logic [CNT_W-1:0]  m2_limit,
  output logic [2:0]        state_o,
  output logic              access_ok,
  output logic              chan_ok,
  output logic              trans_pulse,
  output logic              err_flag
);
  lpm_state_e cur;
  logic       legal, bad, expire, restart;

  lpm_req_check u_check (
    .cur       (cur),
    .req_valid (req_valid),
    .req_code  (req_code),
    .legal     (legal),
    .bad       (bad)
  );

  lpm_idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .cur         (cur),
    .link_active (link_active),
    .restart     (restart),
    .m1_limit    (m1_limit),
    .m2_limit    (m2_limit),
    .expire      (expire)
  );

  lpm_state_core u_core (
    .clk         (clk),
    .rst         (rst),
    .dev_ready   (dev_ready),
    .link_active (link_active),
    .req_legal   (legal),
    .req_bad     (bad),
    .req_valid   (req_valid),
    .req_code    (req_code),
    .chan_start  (chan_start),
    .expire      (expire),
    .state_q     (cur),
    .restart     (restart),
    .access_ok   (access_ok),
    .chan_ok     (chan_ok),
    .trans_pulse (trans_pulse),
    .err_flag    (err_flag)
  );

  assign state_o = cur;
endmodule

// File: tb/link_pm_ctrl_test.sv
module link_pm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dev_ready = 1'b0, link_active = 1'b1, req_valid = 1'b0, chan_start = 1'b0;
  logic [2:0]  req_code = 3'd0;
  logic [15:0] m1_limit = 16'd6, m2_limit = 16'd4;
  logic [2:0]  state_o;
  logic        access_ok, chan_ok, trans_pulse, err_flag;

  int checks = 0, errors = 0;
  logic [2:0] exp_q[$];

  link_pm_ctrl uut (
    .clk(clk), .rst(rst), .dev_ready(dev_ready), .link_active(link_active),
    .req_valid(req_valid), .req_code(req_code), .chan_start(chan_start),
    .m1_limit(m1_limit), .m2_limit(m2_limit), .state_o(state_o),
    .access_ok(access_ok), .chan_ok(chan_ok), .trans_pulse(trans_pulse),
    .err_flag(err_flag)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_req(input logic [2:0] code);
    req_code = code; req_valid = 1'b1;
    tick(1);
    req_valid = 1'b0;
  endtask

  // Monitor: R11 scoreboard of state changes
  always @(posedge clk) begin
    #1;
    if (!rst && trans_pulse) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected strobe", 1, 0);
      end else begin
        check("R11 strobe state", state_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1500000;
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 state", state_o, 0);
    check("R1 access", access_ok, 0);
    check("R1 err", err_flag, 0);
    check("R1 strobe", trans_pulse, 0);
    rst = 1'b0;
    tick(2);
    // R2 / R10: request while in reset is refused
    host_req(3'd2);
    check("R2 stays reset", state_o, 0);
    check("R10 err set in reset", err_flag, 1);
    tick(2);
    check("R10 err sticky", err_flag, 1);
    rst = 1'b1; tick(2); rst = 1'b0;
    check("R1 err cleared", err_flag, 0);
    // R2 ready on dev_ready
    exp_q.push_back(3'd1);
    dev_ready = 1'b1; tick(1);
    check("R2 ready", state_o, 1);
    check("R3 access in ready", access_ok, 1);
    // R4 channel start refused outside active
    chan_start = 1'b1; tick(1); chan_start = 1'b0;
    check("R4 no start in ready", chan_ok, 0);
    // R3 enter active
    exp_q.push_back(3'd2);
    host_req(3'd2);
    check("R3 active", state_o, 2);
    check("R11 strobe now", trans_pulse, 1);
    tick(1);
    check("R11 strobe one cycle", trans_pulse, 0);
    chan_start = 1'b1; tick(1); chan_start = 1'b0;
    check("R4 start in active", chan_ok, 1);
    tick(1);
    check("R4 pulse ends", chan_ok, 0);
    // R5 idle timeout to light suspend
    exp_q.push_back(3'd3);
    link_active = 1'b0;
    tick(5);
    check("R5 before limit", state_o, 2);
    tick(1);
    check("R5 at limit", state_o, 3);
    // R6 wake from light suspend
    exp_q.push_back(3'd2);
    link_active = 1'b1; tick(1);
    check("R6 wake from 3", state_o, 2);
    // R7 fall to low power
    exp_q.push_back(3'd3);
    link_active = 1'b0; tick(6);
    check("R5 again", state_o, 3);
    exp_q.push_back(3'd4);
    tick(3);
    check("R7 before limit", state_o, 3);
    tick(1);
    check("R7 at limit", state_o, 4);
    tick(20);
    check("R7 holds low power", state_o, 4);
    exp_q.push_back(3'd2);
    link_active = 1'b1; tick(1);
    check("R6 wake from 4", state_o, 2);
    // R8 host suspend, activity ignored
    exp_q.push_back(3'd5);
    host_req(3'd5);
    check("R8 host suspend", state_o, 5);
    link_active = 1'b0; tick(1); link_active = 1'b1; tick(3);
    check("R8 activity ignored", state_o, 5);
    check("R11 no strobe in 5", trans_pulse, 0);
    // R10 illegal request in 5
    check("R10 err clear before", err_flag, 0);
    host_req(3'd3);
    check("R10 state kept", state_o, 5);
    check("R10 err set", err_flag, 1);
    host_req(3'd7);
    check("R10 bad code kept", state_o, 5);
    // R9 resume
    exp_q.push_back(3'd2);
    host_req(3'd2);
    check("R9 resume", state_o, 2);
    check("R10 still sticky", err_flag, 1);
    // R12 host request beats activity in light suspend
    exp_q.push_back(3'd3);
    link_active = 1'b0; tick(6);
    check("R12 setup", state_o, 3);
    exp_q.push_back(3'd5);
    link_active = 1'b1;
    host_req(3'd5);
    check("R12 host wins", state_o, 5);
    tick(2);
    check("R11 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule